// File: doc/BRIEF.md
# Four-Mode Power State Controller

This block decides which parts of a device receive clocks and enables. It supports four activity levels: full speed, a reduced-speed mode on the slow clock, an idle mode where only the timekeeping logic runs, and a halt mode where everything stops but keeps its state. From full speed, software may ask for any of the three lower levels. A wake-up request from the edge wake-up controller always brings the device back to full speed.

The outputs are the current mode code and one enable for each of these: the fast oscillator, the fast clock domain, the slow clock domain, the CPU, the timer/watchdog function and each peripheral. In reduced-speed mode, a keep mask chooses which peripherals stay enabled. The idle and halt modes stop the fast oscillator. Leaving either of them therefore goes through a settle phase. In that phase the oscillator is restarted, and the controller counts a programmable number of slow-clock ticks before it enables the CPU again and raises its ready flag. The whole controller runs on one clock. The slow clock reaches it as a one-cycle tick strobe.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, modeCode is 00 (active), every enable output is high, every periphEn bit is high, and ready is high.
- R2: Mode codes are 00 active, 01 power-save, 10 idle and 11 halt. In active mode, a request with reqValid high and modeReq of 01, 10 or 11 shows on modeCode after the next clock edge. A request for 00 has no effect.
- R3: Requests are ignored while modeCode is not 00 and while a settle phase runs. A wakeReq in active mode has no effect.
- R4: In active mode, fastOscEn, fastClkEn, slowClkEn, cpuEn and timerEn are high, all periphEn bits are high, and ready is high.
- R5: In power-save mode (01), fastOscEn, slowClkEn, cpuEn and timerEn are high and fastClkEn is low. periphEn equals psKeep, and ready is low.
- R6: In idle mode (10), only slowClkEn and timerEn are high. All other enables, every periphEn bit and ready are low.
- R7: In halt mode (11), every enable, every periphEn bit and ready are low.
- R8: A wakeReq in power-save mode returns modeCode to 00, with the active enables, after the next clock edge and without a settle phase.
- R9: A wakeReq in idle or halt mode starts a settle phase after the next edge. During this phase modeCode keeps its old value, fastOscEn, slowClkEn and timerEn are high, every other enable and ready are low, and clock cycles without a slowTick do not advance the count. After settleCycles slowTick pulses have been counted (zero means none), the device becomes active on the following edge.
- R10: cpuEn is never high while fastOscEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset, forces active mode |
| modeReq | input | 2 | Requested mode code |
| reqValid | input | 1 | Qualifies modeReq for one cycle |
| wakeReq | input | 1 | Wake-up request from the edge wake-up controller |
| slowTick | input | 1 | One-cycle strobe per slow-clock period |
| settleCycles | input | SETTLE_W | Slow ticks to wait for the fast oscillator to settle |
| psKeep | input | N_PERIPH | Peripherals kept enabled in power-save mode |
| modeCode | output | 2 | Current mode code |
| ready | output | 1 | Device is at full speed with every domain enabled |
| fastOscEn | output | 1 | Fast oscillator run enable |
| fastClkEn | output | 1 | Fast clock domain enable |
| slowClkEn | output | 1 | Slow clock domain enable |
| cpuEn | output | 1 | CPU enable |
| timerEn | output | 1 | Timer/watchdog enable |
| periphEn | output | N_PERIPH | Per-peripheral enables |

## Verification
The bench sends every lower-power target from active mode. For power-save, it goes through every psKeep value, which tells a mask that passes through from one that is forced on or off. In each low mode it issues all four request codes and expects no change. This separates ignoring requests from acting on them. Settle phases are run from both idle and halt with every settle count from 0 to 7. Idle cycles are placed between ticks, and requests and wakes are injected during the wait. This tells counting slow ticks apart from counting clock cycles, and also catches an exit that comes one cycle early or late.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_PSAVE  = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_HALT   = 2'b11
  } pwrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadMode;
    pwrMode_t nextMode;
    logic     clrCnt;
    logic     incCnt;
    logic     settling;
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] modeReq,
  input  logic       wakeReq,
  input  logic       slowTick,
  input  pwrMode_t   curMode,
  input  logic       cntDone,
  output ctlStrobe_t ctl
);

  typedef enum logic {ST_RUN, ST_SETTLE} ctlState_t;

  ctlState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    ctl          = '0;
    ctl.nextMode = MODE_ACTIVE;
    ctl.settling = (state == ST_SETTLE);
    unique case (state)
      ST_RUN: begin
        if (curMode == MODE_ACTIVE) begin
          if (reqValid && (modeReq != MODE_ACTIVE)) begin
            ctl.loadMode = 1'b1;
            ctl.nextMode = pwrMode_t'(modeReq);
          end
        end else if (wakeReq) begin
          if (curMode == MODE_PSAVE) begin
            ctl.loadMode = 1'b1;          // fast oscillator still running
          end else begin
            ctl.clrCnt = 1'b1;            // oscillator restart needs settle
            stateNxt   = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (cntDone) begin
          ctl.loadMode = 1'b1;
          stateNxt     = ST_RUN;
        end else if (slowTick) begin
          ctl.incCnt = 1'b1;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  // R2: a legal request from active lands on the next edge
  a_r2_req_taken: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && curMode == MODE_ACTIVE && reqValid && modeReq != 2'b00)
      |=> (curMode == $past(pwrMode_t'(modeReq))));

  // R3: a low mode holds without a wake
  a_r3_low_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && curMode != MODE_ACTIVE && !wakeReq)
      |=> (curMode == $past(curMode)));

  // R8: wake from power-save returns directly to active
  a_r8_psave_wake: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && curMode == MODE_PSAVE && wakeReq)
      |=> (curMode == MODE_ACTIVE && state == ST_RUN));

endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int N_PERIPH = 4
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [N_PERIPH-1:0] psKeep,
  output pwrMode_t            curMode,
  output logic                cntDone,
  output logic                ready,
  output logic                fastOscEn,
  output logic                fastClkEn,
  output logic                slowClkEn,
  output logic                cpuEn,
  output logic                timerEn,
  output logic [N_PERIPH-1:0] periphEn
);

  pwrMode_t            modeReg;
  logic [SETTLE_W-1:0] settleCnt;
  logic                fullOn, psaveOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             modeReg <= MODE_ACTIVE;
    else if (ctl.loadMode) modeReg <= ctl.nextMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           settleCnt <= '0;
    else if (ctl.clrCnt) settleCnt <= '0;
    else if (ctl.incCnt) settleCnt <= settleCnt + 1'b1;
  end

  // >= keeps the wait bounded if settleCycles drops mid-phase
  assign cntDone = (settleCnt >= settleCycles);
  assign curMode = modeReg;

  always_comb begin
    fullOn    = 1'b0;
    psaveOn   = 1'b0;
    fastOscEn = 1'b0;
    fastClkEn = 1'b0;
    slowClkEn = 1'b0;
    cpuEn     = 1'b0;
    timerEn   = 1'b0;
    if (ctl.settling) begin
      fastOscEn = 1'b1;
      slowClkEn = 1'b1;
      timerEn   = 1'b1;
    end else begin
      unique case (modeReg)
        MODE_ACTIVE: begin
          fullOn    = 1'b1;
          fastOscEn = 1'b1;
          fastClkEn = 1'b1;
          slowClkEn = 1'b1;
          cpuEn     = 1'b1;
          timerEn   = 1'b1;
        end
        MODE_PSAVE: begin
          psaveOn   = 1'b1;
          fastOscEn = 1'b1;
          slowClkEn = 1'b1;
          cpuEn     = 1'b1;
          timerEn   = 1'b1;
        end
        MODE_IDLE: begin
          slowClkEn = 1'b1;
          timerEn   = 1'b1;
        end
        default: ;  // halt: everything low
      endcase
    end
  end

  assign ready = fullOn;

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    assign periphEn[g] = fullOn | (psaveOn & psKeep[g]);
  end

  // R10: CPU never enabled without the fast oscillator
  a_r10_cpu_needs_osc: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |-> fastOscEn);

  // R9: during settle the CPU is held off and the mode is frozen
  a_r9_settle_cpu_off: assert property (@(posedge clk) disable iff (!rstN)
    ctl.settling |-> (!cpuEn && !ready && fastOscEn));

  a_r9_settle_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.settling && !ctl.loadMode) |=> (modeReg == $past(modeReg)));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int N_PERIPH = 4
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeReq,
  input  logic                reqValid,
  input  logic                wakeReq,
  input  logic                slowTick,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [N_PERIPH-1:0] psKeep,
  output logic [1:0]          modeCode,
  output logic                ready,
  output logic                fastOscEn,
  output logic                fastClkEn,
  output logic                slowClkEn,
  output logic                cpuEn,
  output logic                timerEn,
  output logic [N_PERIPH-1:0] periphEn
);

  ctlStrobe_t ctl;
  pwrMode_t   curMode;
  logic       cntDone;

  pwr_mode_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .modeReq  (modeReq),
    .wakeReq  (wakeReq),
    .slowTick (slowTick),
    .curMode  (curMode),
    .cntDone  (cntDone),
    .ctl      (ctl)
  );

  pwr_mode_dp #(.SETTLE_W(SETTLE_W), .N_PERIPH(N_PERIPH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .settleCycles (settleCycles),
    .psKeep       (psKeep),
    .curMode      (curMode),
    .cntDone      (cntDone),
    .ready        (ready),
    .fastOscEn    (fastOscEn),
    .fastClkEn    (fastClkEn),
    .slowClkEn    (slowClkEn),
    .cpuEn        (cpuEn),
    .timerEn      (timerEn),
    .periphEn     (periphEn)
  );

  assign modeCode = curMode;

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

  localparam int SW = 4;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeReq = 2'b00;
  logic          reqValid = 1'b0;
  logic          wakeReq = 1'b0;
  logic          slowTick = 1'b0;
  logic [SW-1:0] settleCycles = '0;
  logic [NP-1:0] psKeep = '0;
  logic [1:0]    modeCode;
  logic          ready, fastOscEn, fastClkEn, slowClkEn, cpuEn, timerEn;
  logic [NP-1:0] periphEn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_W(SW), .N_PERIPH(NP)) uut (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .reqValid(reqValid),
    .wakeReq(wakeReq), .slowTick(slowTick), .settleCycles(settleCycles),
    .psKeep(psKeep), .modeCode(modeCode), .ready(ready),
    .fastOscEn(fastOscEn), .fastClkEn(fastClkEn), .slowClkEn(slowClkEn),
    .cpuEn(cpuEn), .timerEn(timerEn), .periphEn(periphEn)
  );

  // {mode, ready, osc, fastClk, slowClk, cpu, timer, periph}
  function automatic logic [10:0] expVec(int mode, bit settling, logic [NP-1:0] keep);
    if (settling)  return {2'(mode), 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000};
    case (mode)
      0:       return {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111};
      1:       return {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, keep};
      2:       return {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000};
      default: return {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000};
    endcase
  endfunction

  function automatic logic [10:0] actVec();
    return {modeCode, ready, fastOscEn, fastClkEn, slowClkEn, cpuEn, timerEn, periphEn};
  endfunction

  task automatic chk(string tag, logic [10:0] exp);
    logic [10:0] act;
    act = actVec();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", expVec(0, 0, '0));
    step();
    rstN = 1'b1;
    step();
    chk("R1 after reset", expVec(0, 0, '0));
    chk("R4 active enables", expVec(0, 0, '0));

    for (int tgt = 1; tgt <= 3; tgt++) begin
      for (int keep = 0; keep < 8; keep++) begin
        psKeep = NP'(keep);
        // R2: request from active
        reqValid = 1'b1; modeReq = 2'(tgt);
        step();
        reqValid = 1'b0;
        chk(tgt == 1 ? "R2/R5 enter power-save" :
            tgt == 2 ? "R2/R6 enter idle" : "R2/R7 enter halt",
            expVec(tgt, 0, NP'(keep)));
        // R3: all request codes ignored in a low mode
        for (int r = 0; r < 4; r++) begin
          reqValid = 1'b1; modeReq = 2'(r);
          step();
          chk("R3 request ignored in low mode", expVec(tgt, 0, NP'(keep)));
        end
        reqValid = 1'b0;
        if (tgt == 1) begin
          // R5: live mask
          psKeep = ~NP'(keep);
          #1;
          chk("R5 mask follows psKeep", expVec(1, 0, ~NP'(keep)));
          // R8: wake with a simultaneous request, wake wins
          wakeReq = 1'b1; reqValid = 1'b1; modeReq = 2'b11;
          step();
          wakeReq = 1'b0; reqValid = 1'b0;
          chk("R8 power-save wake to active", expVec(0, 0, '0));
        end else begin
          settleCycles = SW'(keep);
          wakeReq = 1'b1;
          step();
          wakeReq = 1'b0;
          chk("R9 settle entered", expVec(tgt, 1, '0));
          for (int k = 0; k < keep; k++) begin
            // no tick: must not advance; requests and wakes ignored (R3)
            reqValid = 1'b1; modeReq = 2'(k % 4); wakeReq = 1'b1;
            step();
            reqValid = 1'b0; wakeReq = 1'b0;
            chk("R9/R3 idle cycle during settle", expVec(tgt, 1, '0));
            slowTick = 1'b1;
            step();
            slowTick = 1'b0;
            chk("R9 still settling after tick", expVec(tgt, 1, '0));
          end
          step();
          chk("R9 active after settle count", expVec(0, 0, '0));
        end
        // R3: wake in active has no effect
        wakeReq = 1'b1;
        step();
        wakeReq = 1'b0;
        chk("R3 wake in active ignored", expVec(0, 0, '0));
        // R2: request for 00 has no effect
        reqValid = 1'b1; modeReq = 2'b00;
        step();
        reqValid = 1'b0;
        chk("R2 request 00 ignored", expVec(0, 0, '0));
        // R10: cpu needs oscillator
        checks++;
        if (cpuEn && !fastOscEn) begin
          errors++;
          $display("FAIL R10: actual cpuEn=%b fastOscEn=%b expected osc high", cpuEn, fastOscEn);
        end
      end
    end

    // R1: reset from halt forces active
    reqValid = 1'b1; modeReq = 2'b11;
    step();
    reqValid = 1'b0;
    chk("R7 halt before reset", expVec(3, 0, '0));
    rstN = 1'b0;
    #1;
    chk("R1 reset from halt", expVec(0, 0, '0));
    step();
    rstN = 1'b1;
    step();
    chk("R1 active after reset release", expVec(0, 0, '0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule